// File: doc/BRIEF.md
# SPI Command Word Receiver

This block is the device side of a write-only SPI link. A host frames each transfer with an active-low chip select and clocks out one 16-bit word. The clock idles low and data is sampled on its rising edge. The receiver works entirely in a fast system clock domain. It brings SCK, MOSI and chip select through synchronizer chains, detects the edges, and shifts the bits in most significant first.

When chip select is released, the block checks the frame length. A frame of exactly 16 bits is split into a 4-bit command (the first four bits received) and a 12-bit operand (the remaining twelve). The word is then handed to a small register bank as a one-cycle strobe. Each register in the bank is tied to its own command code, and register 0 holds the mode configuration. Any other frame length is thrown away and raises a sticky framing-error flag. Nothing is driven back to the host.

Top module: `spi_cmd_rx`

## Requirements
- R1: After reset every register in the bank holds zero, the framing-error flag is low and the word strobe is low.
- R2: Bits are taken most significant first: the first four bits of a frame form the command and the next twelve bits form the operand, with the operand's MSB first.
- R3: Command code 0x1 writes the operand into register 0, the mode configuration register, in bits 11:0 of `reg_file_o`.
- R4: Command code 0x2 writes register 1 (bits 23:12 of `reg_file_o`) and command code 0x3 writes register 2 (bits 35:24).
- R5: A 16-bit frame whose command is any code other than 0x1, 0x2 or 0x3 leaves all registers unchanged.
- R6: A frame that holds any bit count other than 16 when chip select is released, including zero, writes nothing and sets `frame_err_o`. The flag stays high until reset.
- R7: Each valid 16-bit frame gives exactly one single-cycle pulse on `word_stb_o`. A discarded frame gives none.
- R8: SCK edges while chip select is high shift nothing, and the bit count starts from zero in every new frame, including the frame that follows a discarded one.
- R9: MOSI is sampled on the rising edge of SCK. A change of MOSI while SCK is high does not affect the received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the host, idle low |
| mosi_i | input | 1 | Serial data from the host |
| cs_n_i | input | 1 | Active-low chip select, one frame per assertion |
| reg_file_o | output | 36 | Register bank, register n at bits 12n+11:12n |
| frame_err_o | output | 1 | Sticky flag: a frame of the wrong length was seen |
| word_stb_o | output | 1 | One-cycle pulse for each accepted word |

## Verification
The bench sends frames of 0, 15 and 17 bits. A receiver that counted wrongly or failed to clear its counter would then write a register or lose the next good word. It moves MOSI while SCK is high, which catches a receiver that samples on the falling edge. It also toggles SCK with chip select high, which catches shifting outside a frame. Unknown command codes and random operands, mixed with the three write codes, show whether a decoder drops writes, writes the wrong register or writes when it should not.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
   localparam int unsigned FRAME_BITS_DEF = 16;
   localparam int unsigned CMD_BITS_DEF   = 4;

   typedef enum logic [1:0] {
      FR_IDLE = 2'd0,
      FR_GOOD = 2'd1,
      FR_BAD  = 2'd2
   } frame_ev_e;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_cmd_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q[s] <= RST_VAL;
         end else if (s == 0) begin
            chain_q[s] <= d_i;
         end else begin
            chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer
   import spi_cmd_pkg::*;
#(
   parameter int unsigned FRAME_W = FRAME_BITS_DEF,
   parameter int unsigned CMD_W   = CMD_BITS_DEF,
   localparam int unsigned DATA_W = FRAME_W - CMD_W,
   localparam int unsigned CNT_W  = $clog2(FRAME_W + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              mosi_s,
   input  logic              cs_n_s,
   output frame_ev_e         ev_o,
   output logic [CMD_W-1:0]  cmd_o,
   output logic [DATA_W-1:0] data_o
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

   if (CMD_W == 0 || CMD_W >= FRAME_W) begin : g_bad_split
      $error("spi_cmd_framer: CMD_W must lie between 1 and FRAME_W-1");
   end

   logic               sck_q, csn_q;
   logic [FRAME_W-1:0] shreg_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               sck_rise, cs_release;

   assign sck_rise   = sck_s & ~sck_q;
   assign cs_release = cs_n_s & ~csn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q   <= 1'b0;
         csn_q   <= 1'b1;
         shreg_q <= '0;
         cnt_q   <= '0;
         ev_o    <= FR_IDLE;
         cmd_o   <= '0;
         data_o  <= '0;
      end else begin
         sck_q <= sck_s;
         csn_q <= cs_n_s;
         ev_o  <= FR_IDLE;
         if (cs_n_s) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            if (cs_release) begin
               if (cnt_q == CNT_FULL) begin
                  ev_o   <= FR_GOOD;
                  cmd_o  <= shreg_q[FRAME_W-1 -: CMD_W];
                  data_o <= shreg_q[DATA_W-1:0];
               end else begin
                  ev_o <= FR_BAD;
               end
            end
         end else if (sck_rise) begin
            shreg_q <= {shreg_q[FRAME_W-2:0], mosi_s};
            if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R8: the counter never leaves its saturating range
   p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_OVER);
   // R8: a frame begins from an empty counter once chip select has been high
   p_cnt_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_s && csn_q) |=> (cnt_q == '0));
   // R7: a word event lasts one cycle
   p_event_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_o != FR_IDLE) |=> (ev_o == FR_IDLE));
endmodule

// File: rtl/spi_cmd_regbank.sv
module spi_cmd_regbank
   import spi_cmd_pkg::*;
#(
   parameter int unsigned CMD_W     = CMD_BITS_DEF,
   parameter int unsigned DATA_W    = FRAME_BITS_DEF - CMD_BITS_DEF,
   parameter int unsigned NUM_REGS  = 3,
   parameter int unsigned BASE_CODE = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  frame_ev_e                  ev_i,
   input  logic [CMD_W-1:0]           cmd_i,
   input  logic [DATA_W-1:0]          data_i,
   output logic [NUM_REGS*DATA_W-1:0] regs_o,
   output logic                       err_o
);
   if (BASE_CODE + NUM_REGS > (1 << CMD_W)) begin : g_bad_map
      $error("spi_cmd_regbank: register codes exceed the command space");
   end

   logic [NUM_REGS-1:0] hit;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam logic [CMD_W-1:0] CODE = CMD_W'(BASE_CODE + i);
      assign hit[i] = (ev_i == FR_GOOD) && (cmd_i == CODE);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) regs_o[i*DATA_W +: DATA_W] <= '0;
         else if (hit[i]) regs_o[i*DATA_W +: DATA_W] <= data_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_o <= 1'b0;
      else if (ev_i == FR_BAD) err_o <= 1'b1;
   end

   // R5: an unknown code leaves the bank untouched
   p_unknown_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev_i == FR_GOOD) && (hit == '0)) |=> $stable(regs_o));
   // R6: a bad frame writes nothing
   p_bad_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i == FR_BAD) |=> $stable(regs_o));
   // R6: the error flag is sticky
   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);
   // R3: mode register takes the operand
   p_mode_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit[0] |=> (regs_o[DATA_W-1:0] == $past(data_i)));
   // R4: at most one register is addressed per word
   p_one_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
   import spi_cmd_pkg::*;
#(
   parameter int unsigned FRAME_W     = FRAME_BITS_DEF,
   parameter int unsigned CMD_W       = CMD_BITS_DEF,
   parameter int unsigned NUM_REGS    = 3,
   parameter int unsigned BASE_CODE   = 1,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned DATA_W     = FRAME_W - CMD_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sck_i,
   input  logic                       mosi_i,
   input  logic                       cs_n_i,
   output logic [NUM_REGS*DATA_W-1:0] reg_file_o,
   output logic                       frame_err_o,
   output logic                       word_stb_o
);
   logic [2:0]        pins_s;
   frame_ev_e         ev;
   logic [CMD_W-1:0]  cmd;
   logic [DATA_W-1:0] data;

   spi_cmd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d_i({cs_n_i, mosi_i, sck_i}), .q_o(pins_s));

   spi_cmd_framer #(.FRAME_W(FRAME_W), .CMD_W(CMD_W)) u_framer (
      .clk(clk), .rst_n(rst_n),
      .sck_s(pins_s[0]), .mosi_s(pins_s[1]), .cs_n_s(pins_s[2]),
      .ev_o(ev), .cmd_o(cmd), .data_o(data));

   spi_cmd_regbank #(.CMD_W(CMD_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
                     .BASE_CODE(BASE_CODE)) u_bank (
      .clk(clk), .rst_n(rst_n), .ev_i(ev), .cmd_i(cmd), .data_i(data),
      .regs_o(reg_file_o), .err_o(frame_err_o));

   assign word_stb_o = (ev == FR_GOOD);

   // R7: a strobe only follows a chip-select release
   p_stb_after_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      word_stb_o |-> pins_s[2]);
   // R6: a framing error only rises with a discarded frame
   p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_err_o) |-> !word_stb_o);
endmodule

// File: tb/spi_cmd_rx_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_rx_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
   logic [35:0] reg_file;
   logic        ferr, stb;

   int tests = 0, fails = 0, stb_cnt = 0, stb_seen = 0;
   logic [11:0] exp_reg [3];
   logic        exp_err = 1'b0;
   int          exp_stb = 0;

   always #2 clk = ~clk;

   spi_cmd_rx dut_i (.clk(clk), .rst_n(rst_n), .sck_i(sck), .mosi_i(mosi),
                     .cs_n_i(cs_n), .reg_file_o(reg_file), .frame_err_o(ferr),
                     .word_stb_o(stb));

   always @(negedge clk) if (stb) stb_cnt++;

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic void model(input int n, input logic [31:0] val);
      logic [3:0] c;
      if (n == 16) begin
         c = val[15:12];
         if (c >= 4'd1 && c <= 4'd3) exp_reg[c-1] = val[11:0];
         exp_stb++;
      end else begin
         exp_err = 1'b1;
      end
   endfunction

   task automatic send(input int n, input logic [31:0] val, input bit glitch);
      cs_n = 1'b0;
      wait_clk(4);
      for (int i = 0; i < n; i++) begin
         mosi = val[n-1-i];
         wait_clk(3);
         sck = 1'b1;
         if (glitch) begin
            wait_clk(1);
            mosi = ~mosi;
            wait_clk(2);
         end else wait_clk(3);
         sck = 1'b0;
      end
      wait_clk(3);
      cs_n = 1'b1;
      wait_clk(10);
      model(n, val);
   endtask

   task automatic check_all(input string req);
      chk({req, " reg0"}, 64'(reg_file[11:0]), 64'(exp_reg[0]));
      chk({req, " reg1"}, 64'(reg_file[23:12]), 64'(exp_reg[1]));
      chk({req, " reg2"}, 64'(reg_file[35:24]), 64'(exp_reg[2]));
      chk({req, " err"}, 64'(ferr), 64'(exp_err));
      chk({req, " strobes"}, 64'(stb_cnt - stb_seen), 64'(exp_stb));
      stb_seen = stb_cnt;
      exp_stb = 0;
   endtask

   initial begin
      for (int i = 0; i < 3; i++) exp_reg[i] = '0;
      void'($urandom(32'd1234));
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(4);
      check_all("R1 reset");
      send(16, 32'h1A5C, 0); check_all("R3 mode write");
      send(16, 32'h2123, 0); check_all("R4 reg1 write");
      send(16, 32'h3FE1, 0); check_all("R4 reg2 write");
      send(16, 32'h18F0, 0); check_all("R2 bit order");
      send(16, 32'h0777, 0); check_all("R5 code 0");
      send(16, 32'hF555, 0); check_all("R5 code F");
      send(16, 32'h2C3A, 1); check_all("R9 rising-edge sample");
      cs_n = 1'b1;
      for (int i = 0; i < 5; i++) begin
         mosi = 1'b1; sck = 1'b1; wait_clk(3); sck = 1'b0; wait_clk(3);
      end
      send(16, 32'h3009, 0); check_all("R8 idle clocks ignored");
      send(15, 32'h1FFF, 0); check_all("R6 short frame");
      send(16, 32'h1123, 0); check_all("R8 recount after short");
      send(17, 32'h13456, 0); check_all("R6 long frame");
      send(0, 32'h0, 0);     check_all("R6 empty frame");
      send(16, 32'h2ABC, 0); check_all("R6 sticky and R7 strobe");
      for (int k = 0; k < 40; k++) begin
         int r = $urandom_range(0, 9);
         int n = (r == 0) ? 15 : (r == 1) ? 17 : 16;
         logic [31:0] v = $urandom;
         if (r >= 2 && r <= 7) v[15:12] = 4'($urandom_range(1, 3));
         send(n, v & ((32'd1 << n) - 1), (r == 8));
         check_all("R7 random R2 R4 R5");
      end
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule